// File: doc/BRIEF.md
# Chained Sync Counter Bank

A bank of programmable counters that together build display timing: line sync, frame sync, line-active and pixel-active windows. Each counter steps on a selectable event source. That source is the pixel-clock enable or the event strobe of any counter in the bank, so counters can be chained into line, frame and active-area generators. A counter can also be sent back to its starting state by a selectable clear source. After a clear it waits a programmable number of events from an offset source. It then counts periods of `run + 1` events. It can stop after a programmed number of periods, or run without limit.

Each counter drives one event strobe, high for one cycle at every period wrap. It also drives one sync output. That output is either a copy of the strobe, or a window whose edges are placed in half-event units of a trigger source and counted from the start of the period. Three 32-bit words per counter are written through a simple write port. A word that holds an out-of-range value is refused and leaves the stored settings untouched.

Source selectors are 4 bits wide: code 0 is no source, code n (1 to NCNT) is the strobe of counter n-1 seen one cycle late, and code 15 is the `pix_en` input.

Top module: `sync_bank`

## Requirements
- R1: Word 0 (`cfg_sel`=0) holds the period limit in bits 31:20, the step source in bits 19:16, the offset count in bits 15:4 and the offset source in bits 3:0. Word 0 is always accepted. Once running, a counter raises `evt_out` for exactly one cycle on the step event that completes `limit + 1` step events, and then restarts from zero.
- R2: Source code 0 never produces an event. Code 15 is `pix_en` in the same cycle. Code n in 1..NCNT is `evt_out[n-1]` delayed by one clock, so a counter stepping on counter n-1 steps on the edge after that strobe.
- R3: After a clear, or after `bank_en` rises, a counter with a nonzero offset count consumes that many offset-source events before it begins counting. A counter with offset count 0 begins on the next edge without consuming an event.
- R4: Word 2 holds the repeat count in bits 15:0. A nonzero value stops the counter after that many periods, with no strobes and a low sync output, until its next clear. A value of 0 lets it run without limit.
- R5: Word 1 bits 30:27 select a clear source. An event on it returns the counter to the offset-wait state on that edge, and the clear takes priority over a step event on the same edge.
- R6: Word 1 bit 31 enables window mode, bits 15:12 select the trigger source, bits 9:0 the rise position and bits 25:16 the fall position. In window mode `sync_out` is high while twice the number of trigger events since the period start lies in [rise, fall). The count restarts at every wrap and at the start of counting.
- R7: With word 1 bit 31 clear, `sync_out` equals the counter's `evt_out` strobe.
- R8: A write is refused, with `cfg_reject` high in the cycle after it and the stored word unchanged, when word 1 has bit 10 or bit 26 set (an edge position of 0x400 or more), when word 2 holds 0x1000 or more in bits 15:0, when `cfg_sel` is 3, or when `cfg_idx` is at least NCNT.
- R9: During reset, and on each edge with `bank_en` low, all counters return to the offset-wait state, and `sync_out` and `evt_out` are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock event enable (source code 15) |
| bank_en | input | 1 | Runs the bank when high; holds every counter cleared when low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (3) | Counter number being written |
| cfg_sel | input | 2 | Word select: 0, 1 or 2 |
| cfg_data | input | 32 | Configuration word |
| cfg_reject | output | 1 | Pulses in the cycle after a refused write |
| sync_out | output | NCNT (8) | Per-counter sync output |
| evt_out | output | NCNT (8) | Per-counter period-wrap strobe |

## Verification
The case that is hardest to reach from the ports is a counter that has hit its repeat limit, sits stopped, and is then cleared and re-armed by another counter's strobe, with an offset wait in between. The stimulus builds a three-level chain. A pixel-stepped line counter feeds a frame counter with an 8-line period. A third counter steps on lines, waits two lines of offset, stops after three periods and is cleared by the frame strobe. Two full frames are compared against closed-form expectations, so the stop, the clear, the offset and the restart are each seen twice. Refused writes are issued before the run, and the run itself shows that the earlier settings were kept.

// File: rtl/sbk_pkg.sv
package sbk_pkg;

  localparam int WORD_W = 32;
  localparam int SEL_W  = 4;
  localparam int CNT_W  = 12;
  localparam int REP_W  = 12;
  localparam int POS_W  = 10;
  localparam int TC_W   = POS_W - 1;
  localparam int SRC_N  = 2 ** SEL_W;
  localparam logic [SEL_W-1:0] SRC_PIX = '1;

  typedef enum logic [1:0] {PH_WAIT, PH_RUN, PH_DONE} phase_e;

  typedef struct packed {
    logic             pol_en;
    logic [SEL_W-1:0] clr_src;
    logic [SEL_W-1:0] trig_src;
    logic [SEL_W-1:0] run_src;
    logic [SEL_W-1:0] off_src;
    logic [POS_W-1:0] up;
    logic [POS_W-1:0] down;
    logic [CNT_W-1:0] run_lim;
    logic [CNT_W-1:0] off_lim;
    logic [REP_W-1:0] rep_lim;
  } cnt_cfg_t;

  function automatic cnt_cfg_t unpack_cfg(input logic [WORD_W-1:0] w0,
                                          input logic [WORD_W-1:0] w1,
                                          input logic [WORD_W-1:0] w2);
    cnt_cfg_t c;
    c.run_lim  = w0[31:20];
    c.run_src  = w0[19:16];
    c.off_lim  = w0[15:4];
    c.off_src  = w0[3:0];
    c.pol_en   = w1[31];
    c.clr_src  = w1[30:27];
    c.down     = w1[25:16];
    c.trig_src = w1[15:12];
    c.up       = w1[9:0];
    c.rep_lim  = w2[11:0];
    return c;
  endfunction

  function automatic logic word_ok(input logic [1:0] sel, input logic [WORD_W-1:0] d);
    case (sel)
      2'd0:    return 1'b1;
      2'd1:    return !d[10] && !d[26];
      2'd2:    return d[15:12] == 4'd0;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sbk_cfg_store.sv
module sbk_cfg_store
  import sbk_pkg::*;
#(
  parameter int NCNT  = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] data,
  output logic              reject,
  output cnt_cfg_t          cfg [NCNT]
);

  logic [WORD_W-1:0] w0_q [NCNT];
  logic [WORD_W-1:0] w1_q [NCNT];
  logic [WORD_W-1:0] w2_q [NCNT];
  logic              in_range;
  logic              accept;

  assign in_range = 32'(idx) < NCNT;
  assign accept   = we && in_range && word_ok(sel, data);

  always_ff @(posedge clk) begin
    if (rst) reject <= 1'b0;
    else     reject <= we && !accept;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        w0_q[g] <= '0;
        w1_q[g] <= '0;
        w2_q[g] <= '0;
      end else if (accept && 32'(idx) == g) begin
        case (sel)
          2'd0:    w0_q[g] <= data;
          2'd1:    w1_q[g] <= data;
          default: w2_q[g] <= data;
        endcase
      end
    end
    assign cfg[g] = unpack_cfg(w0_q[g], w1_q[g], w2_q[g]);
  end

endmodule

// File: rtl/sbk_counter.sv
module sbk_counter
  import sbk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  cnt_cfg_t         cfg,
  input  logic [SRC_N-1:0] src_ev,
  output logic             evt_o,
  output logic             pulse_o
);

  phase_e           ph_q, ph_n;
  logic [CNT_W-1:0] woff_q, woff_n;
  logic [CNT_W-1:0] run_q, run_n;
  logic [TC_W-1:0]  tc_q, tc_n;
  logic [REP_W-1:0] rep_q, rep_n;
  logic             evt_n, pulse_n;
  logic [POS_W-1:0] pos_n;
  logic             run_ev, off_ev, trig_ev, clr_ev;

  assign run_ev  = src_ev[cfg.run_src];
  assign off_ev  = src_ev[cfg.off_src];
  assign trig_ev = src_ev[cfg.trig_src];
  assign clr_ev  = src_ev[cfg.clr_src];

  always_comb begin
    ph_n   = ph_q;
    woff_n = woff_q;
    run_n  = run_q;
    tc_n   = tc_q;
    rep_n  = rep_q;
    evt_n  = 1'b0;
    if (!en || clr_ev) begin
      ph_n   = PH_WAIT;
      woff_n = '0;
      run_n  = '0;
      tc_n   = '0;
      rep_n  = '0;
    end else begin
      case (ph_q)
        PH_WAIT: begin
          if (cfg.off_lim == '0) begin
            ph_n  = PH_RUN;
            run_n = '0;
            tc_n  = '0;
            rep_n = '0;
          end else if (off_ev) begin
            if (woff_q + CNT_W'(1) == cfg.off_lim) begin
              ph_n   = PH_RUN;
              woff_n = '0;
              run_n  = '0;
              tc_n   = '0;
              rep_n  = '0;
            end else begin
              woff_n = woff_q + CNT_W'(1);
            end
          end
        end
        PH_RUN: begin
          if (trig_ev && tc_q != '1) tc_n = tc_q + TC_W'(1);
          if (run_ev) begin
            if (run_q == cfg.run_lim) begin
              run_n = '0;
              tc_n  = '0;
              evt_n = 1'b1;
              if (cfg.rep_lim != '0) begin
                rep_n = rep_q + REP_W'(1);
                if (rep_q + REP_W'(1) == cfg.rep_lim) ph_n = PH_DONE;
              end
            end else begin
              run_n = run_q + CNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
    pos_n   = {tc_n, 1'b0};
    pulse_n = cfg.pol_en ? (ph_n == PH_RUN && pos_n >= cfg.up && pos_n < cfg.down)
                         : evt_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_WAIT;
      woff_q  <= '0;
      run_q   <= '0;
      tc_q    <= '0;
      rep_q   <= '0;
      evt_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      woff_q  <= woff_n;
      run_q   <= run_n;
      tc_q    <= tc_n;
      rep_q   <= rep_n;
      evt_o   <= evt_n;
      pulse_o <= pulse_n;
    end
  end

endmodule

// File: rtl/sync_bank.sv
module sync_bank
  import sbk_pkg::*;
#(
  parameter int NCNT  = 8,
  parameter int IDX_W = (NCNT > 1) ? $clog2(NCNT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              bank_en,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_data,
  output logic              cfg_reject,
  output logic [NCNT-1:0]   sync_out,
  output logic [NCNT-1:0]   evt_out
);

  cnt_cfg_t         cfg [NCNT];
  logic [SRC_N-1:0] src_ev;

  initial begin
    if (NCNT > SRC_N - 2) $error("NCNT too large for the source code width");
  end

  sbk_cfg_store #(.NCNT(NCNT), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .idx    (cfg_idx),
    .sel    (cfg_sel),
    .data   (cfg_data),
    .reject (cfg_reject),
    .cfg    (cfg)
  );

  always_comb begin
    src_ev                 = '0;
    src_ev[NCNT:1]         = evt_out;
    src_ev[SRC_PIX]        = pix_en;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    sbk_counter u_cnt (
      .clk     (clk),
      .rst     (rst),
      .en      (bank_en),
      .cfg     (cfg[g]),
      .src_ev  (src_ev),
      .evt_o   (evt_out[g]),
      .pulse_o (sync_out[g])
    );
  end

endmodule

// File: rtl/sync_bank_chk.sv
module sync_bank_chk #(
  parameter int NCNT  = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bank_en,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_idx,
  input logic [1:0]       cfg_sel,
  input logic [31:0]      cfg_data,
  input logic             cfg_reject,
  input logic [NCNT-1:0]  sync_out,
  input logic [NCNT-1:0]  evt_out
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bank_en |=> (sync_out == '0 && evt_out == '0)); // R9

  AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (evt_out != '0) |-> $past(bank_en)); // R9

  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cfg_reject |-> $past(cfg_we)); // R8

  AST_BAD_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd2 && cfg_data[15:12] != 4'd0) |=> cfg_reject); // R8

  AST_BAD_EDGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd1 && (cfg_data[10] || cfg_data[26])) |=> cfg_reject); // R8

  AST_WORD0_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd0 && 32'(cfg_idx) < NCNT) |=> !cfg_reject); // R1

endmodule

bind sync_bank sync_bank_chk #(.NCNT(NCNT), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bank_en    (bank_en),
  .cfg_we     (cfg_we),
  .cfg_idx    (cfg_idx),
  .cfg_sel    (cfg_sel),
  .cfg_data   (cfg_data),
  .cfg_reject (cfg_reject),
  .sync_out   (sync_out),
  .evt_out    (evt_out)
);

// File: tb/sync_bank_bench.sv
module sync_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCNT       = 8;
  localparam int IDX_W      = 3;
  localparam int WIN        = 200;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pix_en = 1'b1;
  logic             bank_en = 1'b0;
  logic             cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [1:0]       cfg_sel = '0;
  logic [31:0]      cfg_data = '0;
  logic             cfg_reject;
  logic [NCNT-1:0]  sync_out;
  logic [NCNT-1:0]  evt_out;

  sync_bank #(.NCNT(NCNT)) u_sync_bank (
    .clk(clk), .rst(rst), .pix_en(pix_en), .bank_en(bank_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .cfg_reject(cfg_reject), .sync_out(sync_out), .evt_out(evt_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         k;
    logic [3:0] o;
    logic [3:0] e;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;
  bit   ended = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input int idx, input int sel, input logic [31:0] d,
                    input logic exp_rej, input string tag);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_idx  = IDX_W'(idx);
    cfg_sel  = 2'(sel);
    cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(tag, 32'(cfg_reject), 32'(exp_rej));
  endtask

  function automatic logic [31:0] w0(int lim, int rs, int off, int os);
    return (32'(lim) << 20) | (32'(rs) << 16) | (32'(off) << 4) | 32'(os);
  endfunction

  function automatic logic [31:0] w1(int pol, int clr, int dn, int trg, int up);
    return (32'(pol) << 31) | (32'(clr) << 27) | (32'(dn) << 16) | (32'(trg) << 12) | 32'(up);
  endfunction

  // Driver side of the scoreboard: expected values from the requirement formulas.
  task automatic push_window(input int n);
    for (int k = 0; k < n; k++) begin
      exp_t x;
      int   j;
      j = k % 80;
      x.k = k;
      x.o = '0;
      x.e = '0;
      x.o[0] = (k % 10) < 2;                        // R6: 2 of every 10 pixels
      x.e[0] = (k > 0) && (k % 10 == 0);            // R1: wrap after 10 events
      x.o[1] = (j >= 11) && (j <= 20);              // R2: chained on line strobe
      x.e[1] = (k >= 81) && (j == 1);
      x.e[2] = (j == 31) || (j == 41) || (j == 51); // R3 offset, R4 repeat, R5 clear
      x.o[2] = x.e[2];                              // R7
      q.push_back(x);
    end
  endtask

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk($sformatf("R6 ctr0 window k=%0d", x.k), 32'(sync_out[0]), 32'(x.o[0]));
      chk($sformatf("R1 ctr0 strobe k=%0d", x.k), 32'(evt_out[0]), 32'(x.e[0]));
      chk($sformatf("R2 ctr1 window k=%0d", x.k), 32'(sync_out[1]), 32'(x.o[1]));
      chk($sformatf("R2 ctr1 strobe k=%0d", x.k), 32'(evt_out[1]), 32'(x.e[1]));
      chk($sformatf("R3 R4 R5 ctr2 strobe k=%0d", x.k), 32'(evt_out[2]), 32'(x.e[2]));
      chk($sformatf("R7 ctr2 sync k=%0d", x.k), 32'(sync_out[2]), 32'(x.o[2]));
      chk($sformatf("R2 ctr3 no source k=%0d", x.k), 32'({sync_out[3], evt_out[3]}), 32'(0));
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset sync", 32'(sync_out), 32'(0));
    chk("R9 reset strobe", 32'(evt_out), 32'(0));
    chk("R9 reset reject", 32'(cfg_reject), 32'(0));

    // Counter 0: pixel line counter, period 10, 2-pixel window.
    wr(0, 0, w0(9, 15, 0, 0), 1'b0, "R1 word0 ctr0");
    wr(0, 1, w1(1, 0, 4, 15, 0), 1'b0, "R6 word1 ctr0");
    // Counter 1: steps on counter 0, period 8 lines, window over line 1.
    wr(1, 0, w0(7, 1, 0, 0), 1'b0, "R1 word0 ctr1");
    wr(1, 1, w1(1, 0, 4, 1, 2), 1'b0, "R6 word1 ctr1");
    // Counter 2: line stepped, 2-line offset, 3 periods, cleared by counter 1.
    wr(2, 0, w0(0, 1, 2, 1), 1'b0, "R3 word0 ctr2");
    wr(2, 1, w1(0, 2, 0, 0, 0), 1'b0, "R5 word1 ctr2");
    wr(2, 2, 32'd3, 1'b0, "R4 word2 ctr2");

    // Refused writes; the run below shows the old values were kept.
    wr(2, 2, 32'h0000_1000, 1'b1, "R8 repeat out of range");
    wr(0, 1, w1(1, 0, 12'h404, 15, 0), 1'b1, "R8 fall position out of range");
    wr(0, 1, w1(1, 0, 4, 15, 12'h400), 1'b1, "R8 rise position out of range");
    wr(0, 3, 32'h0, 1'b1, "R8 reserved word select");

    push_window(WIN);
    @(negedge clk);
    bank_en = 1'b1;
    @(posedge clk);
    #1 mon_on = 1'b1;
    wait (q.size() == 0);
    @(negedge clk);
    mon_on  = 1'b0;
    bank_en = 1'b0;
    @(negedge clk);
    chk("R9 disabled sync", 32'(sync_out), 32'(0));
    chk("R9 disabled strobe", 32'(evt_out), 32'(0));
    repeat (12) @(negedge clk);
    chk("R9 held sync", 32'(sync_out), 32'(0));
    finish_run();
  end

endmodule